// File: doc/BRIEF.md
# Effective Address Classifier

This block sorts the six-bit operand specifier of an instruction into one of eleven addressing classes. The upper three bits are the mode and the lower three bits are the register. For each specifier it also reports three things: the register the operand uses, as a single 0 to 15 number where 0 to 7 are data registers and 8 to 15 are address registers; how many 16-bit extension words follow the opcode for that class and the given operand size; and whether the specifier is illegal.

An instruction decoder presents the specifier and a size code together with a valid strobe. One cycle later the classification appears on registered outputs, together with a one-cycle done pulse. The outputs then hold until the next strobe. Fetching the extension words and computing the address are left to later stages.

Operand size codes: 0 byte, 1 word, 2 long, 3 eight-byte, 4 twelve-byte, 5 to 7 reserved. Class codes on `cls_o`: 0 register direct, 1 immediate, 2 indirect, 3 indirect postincrement, 4 indirect predecrement, 5 indirect with 16-bit displacement, 6 indexed, 7 absolute short, 8 absolute long, 9 PC plus displacement, 10 PC indexed, 15 none.

Top module: `eac_classifier`

## Requirements
- R1: During and just after reset, `done_o` and `illegal_o` are 0, `cls_o` is 15, and `reg_o` and `ext_words_o` are 0.
- R2: When specifier bits [5:4] are both 0, the class is 0 (register direct), `reg_o` equals specifier bits [3:0], and the extension count is 0.
- R3: Modes 2, 3, 4 and 5 (bits [5:3]) give classes 2, 3, 4 and 5. `reg_o` is 8 plus bits [2:0]. The extension count is 0 for modes 2 to 4 and 1 for mode 5, whatever the size code.
- R4: Mode 6 gives class 6 (indexed) with `reg_o` equal to 8 plus bits [2:0] and an extension count of 1.
- R5: In mode 7, sub-modes 0, 1, 2 and 3 (bits [2:0]) give classes 7, 8, 9 and 10, with extension counts 1, 2, 1 and 1. `reg_o` equals bits [2:0].
- R6: Specifier octal 74 is immediate (class 1) and is recognised before the mode-7 sub-decode, so `reg_o` is 12. Its extension count is 1 for size 0 or 1, 2 for size 2, 4 for size 3 and 6 for size 4.
- R7: Mode 7 sub-modes 5, 6 and 7 raise `illegal_o`, and so does immediate with a reserved size code (5 to 7). `reg_o` keeps the value given in R5 or R6.
- R8: Whenever `illegal_o` is 1, `cls_o` is 15 and `ext_words_o` is 0. Whenever it is 0, `cls_o` is a legal class (0 to 10).
- R9: `done_o` is 1 in exactly the cycle after each cycle in which `valid_i` is 1, and 0 otherwise.
- R10: While `valid_i` stays low, all outputs hold their last values, whatever the specifier and size inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Specifier and size are valid this cycle |
| spec_i | input | 6 | Operand specifier, mode in [5:3], register in [2:0] |
| size_i | input | 3 | Operand size code |
| done_o | output | 1 | One-cycle pulse, result registered |
| cls_o | output | 4 | Addressing class code |
| reg_o | output | 4 | Register number 0 to 15 |
| ext_words_o | output | 3 | Extension words needed |
| illegal_o | output | 1 | Specifier or size combination is illegal |

## Verification
Two functions can act on one specifier in the same cycle: the immediate check and the mode-7 sub-decode both claim octal 74. Beside them, the size-dependent word count and the reserved-size illegal check both act on that specifier. The bench provokes both overlaps by sweeping every specifier against legal and reserved size codes, with strobes back to back. A scoreboard judges that octal 74 comes out as immediate with register 12 and the per-size count, or as illegal with class 15 and a count of 0, and never as a mode-7 sub-case.

// File: rtl/eac_pkg.sv
package eac_pkg;

    localparam int SPEC_W = 6;
    localparam int SIZE_W = 3;
    localparam int REG_W  = 4;
    localparam int EXT_W  = 3;
    localparam int CLS_W  = 4;

    // Specifier value that selects immediate data (octal 74)
    localparam logic [SPEC_W-1:0] SPEC_IMMEDIATE = 6'o74;

    typedef enum logic [CLS_W-1:0] {
        CLS_REG_DIRECT = 4'd0,
        CLS_IMMEDIATE  = 4'd1,
        CLS_INDIRECT   = 4'd2,
        CLS_POST_INC   = 4'd3,
        CLS_PRE_DEC    = 4'd4,
        CLS_DISP16     = 4'd5,
        CLS_INDEXED    = 4'd6,
        CLS_ABS_SHORT  = 4'd7,
        CLS_ABS_LONG   = 4'd8,
        CLS_PC_DISP    = 4'd9,
        CLS_PC_INDEXED = 4'd10,
        CLS_NONE       = 4'd15
    } ea_class_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 3'd0,
        SZ_WORD  = 3'd1,
        SZ_LONG  = 3'd2,
        SZ_OCTET = 3'd3,
        SZ_TRIPL = 3'd4
    } op_size_e;

    typedef struct packed {
        logic              done;
        ea_class_e         cls;
        logic [REG_W-1:0]  regnum;
        logic [EXT_W-1:0]  ext_words;
        logic              illegal;
    } eac_result_t;

endpackage

// File: rtl/eac_mode_decode.sv
module eac_mode_decode
    import eac_pkg::*;
#(
    parameter int SPEC_BITS = SPEC_W,
    parameter int REG_BITS  = REG_W
) (
    input  logic [SPEC_BITS-1:0] spec_i,
    output ea_class_e            cls_o,
    output logic [REG_BITS-1:0]  reg_o,
    output logic                 is_imm_o,
    output logic                 bad_mode_o
);
    localparam int HALF = SPEC_BITS / 2;

    logic [HALF-1:0] mode_w;
    logic [HALF-1:0] rsel_w;

    assign mode_w = spec_i[SPEC_BITS-1:HALF];
    assign rsel_w = spec_i[HALF-1:0];

    always_comb begin
        // Default: address register bank selected by the low bits
        cls_o      = CLS_NONE;
        reg_o      = REG_BITS'(8) + REG_BITS'(rsel_w);
        is_imm_o   = 1'b0;
        bad_mode_o = 1'b0;

        if (mode_w[HALF-1:HALF-2] == 2'b00) begin
            cls_o = CLS_REG_DIRECT;
            reg_o = spec_i[REG_BITS-1:0];
        end else if (spec_i == SPEC_IMMEDIATE) begin
            // Must win over the mode-7 sub-decode
            cls_o    = CLS_IMMEDIATE;
            is_imm_o = 1'b1;
        end else begin
            unique case (mode_w)
                3'd2:    cls_o = CLS_INDIRECT;
                3'd3:    cls_o = CLS_POST_INC;
                3'd4:    cls_o = CLS_PRE_DEC;
                3'd5:    cls_o = CLS_DISP16;
                3'd6:    cls_o = CLS_INDEXED;
                default: begin
                    reg_o = REG_BITS'(rsel_w);
                    unique case (rsel_w)
                        3'd0:    cls_o = CLS_ABS_SHORT;
                        3'd1:    cls_o = CLS_ABS_LONG;
                        3'd2:    cls_o = CLS_PC_DISP;
                        3'd3:    cls_o = CLS_PC_INDEXED;
                        default: bad_mode_o = 1'b1;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/eac_ext_count.sv
module eac_ext_count
    import eac_pkg::*;
#(
    parameter int SIZE_BITS = SIZE_W,
    parameter int EXT_BITS  = EXT_W,
    parameter int NUM_SIZES = 5
) (
    input  ea_class_e            cls_i,
    input  logic [SIZE_BITS-1:0] size_i,
    output logic [EXT_BITS-1:0]  ext_o,
    output logic                 size_bad_o
);
    // Immediate word count per size code, built in a generate loop
    logic [EXT_BITS-1:0] imm_words [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_imm
        // bytes: 1,2,4,8,12 -> words rounded up
        localparam int BYTES = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 :
                               (s == 3) ? 8 : 12;
        assign imm_words[s] = EXT_BITS'((BYTES + 1) / 2);
    end

    always_comb begin
        size_bad_o = (int'(size_i) >= NUM_SIZES);
        ext_o      = '0;
        unique case (cls_i)
            CLS_DISP16, CLS_INDEXED, CLS_ABS_SHORT,
            CLS_PC_DISP, CLS_PC_INDEXED: ext_o = EXT_BITS'(1);
            CLS_ABS_LONG:                ext_o = EXT_BITS'(2);
            CLS_IMMEDIATE: begin
                for (int s = 0; s < NUM_SIZES; s++) begin
                    if (int'(size_i) == s) ext_o = imm_words[s];
                end
            end
            default:                     ext_o = '0;
        endcase
    end
endmodule

// File: rtl/eac_classifier.sv
module eac_classifier
    import eac_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [SPEC_W-1:0] spec_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              done_o,
    output logic [CLS_W-1:0]  cls_o,
    output logic [REG_W-1:0]  reg_o,
    output logic [EXT_W-1:0]  ext_words_o,
    output logic              illegal_o
);
    ea_class_e           dec_cls;
    logic [REG_W-1:0]    dec_reg;
    logic                dec_imm;
    logic                dec_bad;
    logic [EXT_W-1:0]    cnt_ext;
    logic                cnt_size_bad;

    eac_result_t res_d, res_q;

    eac_mode_decode #(
        .SPEC_BITS (SPEC_W),
        .REG_BITS  (REG_W)
    ) u_decode (
        .spec_i     (spec_i),
        .cls_o      (dec_cls),
        .reg_o      (dec_reg),
        .is_imm_o   (dec_imm),
        .bad_mode_o (dec_bad)
    );

    eac_ext_count #(
        .SIZE_BITS (SIZE_W),
        .EXT_BITS  (EXT_W)
    ) u_count (
        .cls_i      (dec_cls),
        .size_i     (size_i),
        .ext_o      (cnt_ext),
        .size_bad_o (cnt_size_bad)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = valid_i;
        if (valid_i) begin
            res_d.regnum = dec_reg;
            if (dec_bad || (dec_imm && cnt_size_bad)) begin
                res_d.cls       = CLS_NONE;
                res_d.ext_words = '0;
                res_d.illegal   = 1'b1;
            end else begin
                res_d.cls       = dec_cls;
                res_d.ext_words = cnt_ext;
                res_d.illegal   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '{done: 1'b0, cls: CLS_NONE, regnum: '0,
                       ext_words: '0, illegal: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o      = res_q.done;
    assign cls_o       = res_q.cls;
    assign reg_o       = res_q.regnum;
    assign ext_words_o = res_q.ext_words;
    assign illegal_o   = res_q.illegal;
endmodule

// File: rtl/eac_classifier_chk.sv
module eac_classifier_chk
    import eac_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [SPEC_W-1:0] spec_i,
    input logic [SIZE_W-1:0] size_i,
    input logic              done_o,
    input logic [CLS_W-1:0]  cls_o,
    input logic [REG_W-1:0]  reg_o,
    input logic [EXT_W-1:0]  ext_words_o,
    input logic              illegal_o
);
    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> done_o);
    assert_no_spurious_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !done_o);
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(cls_o) && $stable(reg_o) && $stable(ext_words_o)
                      && $stable(illegal_o)));
    assert_illegal_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (cls_o == 4'd15 && ext_words_o == '0));
    assert_legal_class_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !illegal_o && done_o |-> (cls_o <= 4'd10));
    assert_direct_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && spec_i[5:4] == 2'b00 |=>
            (cls_o == 4'd0 && reg_o == $past(spec_i[3:0])));
    assert_immediate_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && spec_i == 6'o74 && size_i <= 3'd4 |=>
            (cls_o == 4'd1 && reg_o == 4'd12 && !illegal_o));
    assert_bad_submode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && spec_i[5:3] == 3'd7 && spec_i[2:0] > 3'd4 |=> illegal_o);
    assert_mode7_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && spec_i[5:3] == 3'd7 && spec_i[2:0] != 3'd4 |=>
            (reg_o == {1'b0, $past(spec_i[2:0])}));
endmodule

bind eac_classifier eac_classifier_chk u_chk (.*);

// File: tb/eac_classifier_tb_top.sv
module eac_classifier_tb_top;
    import eac_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [5:0] spec = '0;
    logic [2:0] size = '0;
    logic       done;
    logic [3:0] cls;
    logic [3:0] regn;
    logic [2:0] ext;
    logic       ill;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [3:0] cls;
        logic [3:0] regn;
        logic [2:0] ext;
        logic       ill;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    eac_classifier dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .spec_i(spec),
        .size_i(size), .done_o(done), .cls_o(cls), .reg_o(regn),
        .ext_words_o(ext), .illegal_o(ill)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference model written from the requirements
    function automatic exp_t model(input logic [5:0] s, input logic [2:0] z,
                                   output string tag);
        exp_t e;
        e = '{cls: 4'd15, regn: 4'd0, ext: 3'd0, ill: 1'b0};
        if (s[5:4] == 2'b00) begin
            e.cls = 4'd0; e.regn = s[3:0]; tag = "R2";
        end else if (s == 6'o74) begin
            e.regn = 4'd12;
            if (z <= 3'd4) begin
                e.cls = 4'd1; tag = "R6";
                case (z)
                    3'd0, 3'd1: e.ext = 3'd1;
                    3'd2:       e.ext = 3'd2;
                    3'd3:       e.ext = 3'd4;
                    default:    e.ext = 3'd6;
                endcase
            end else begin
                e.ill = 1'b1; tag = "R7";
            end
        end else if (s[5:3] == 3'd7) begin
            e.regn = {1'b0, s[2:0]};
            case (s[2:0])
                3'd0: begin e.cls = 4'd7;  e.ext = 3'd1; tag = "R5"; end
                3'd1: begin e.cls = 4'd8;  e.ext = 3'd2; tag = "R5"; end
                3'd2: begin e.cls = 4'd9;  e.ext = 3'd1; tag = "R5"; end
                3'd3: begin e.cls = 4'd10; e.ext = 3'd1; tag = "R5"; end
                default: begin e.ill = 1'b1; tag = "R7"; end
            endcase
        end else begin
            e.regn = 4'd8 + {1'b0, s[2:0]};
            e.cls  = {1'b0, s[5:3]};
            e.ext  = (s[5:3] >= 3'd5) ? 3'd1 : 3'd0;
            tag    = (s[5:3] == 3'd6) ? "R4" : "R3";
        end
        return e;
    endfunction

    task automatic send(input logic [5:0] s, input logic [2:0] z);
        string t;
        exp_t e;
        @(negedge clk);
        valid = 1'b1; spec = s; size = z;
        e = model(s, z, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0;
            spec = 6'($urandom);
            size = 3'($urandom);
        end
    endtask

    // Monitor: pops and compares as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "done without request", 32'(done), 32'd0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cls == e.cls, t, "class", 32'(cls), 32'(e.cls));
                    check(regn == e.regn, t, "register", 32'(regn), 32'(e.regn));
                    check(ext == e.ext, t, "ext words", 32'(ext), 32'(e.ext));
                    check(ill == e.ill, (e.ill ? "R7" : "R8"), "illegal",
                          32'(ill), 32'(e.ill));
                    check(!ill || (cls == 4'd15 && ext == 3'd0), "R8",
                          "illegal exclusive", 32'(cls), 32'd15);
                end
            end
        end
    end

    initial begin
        exp_t held;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1", "done", 32'(done), 32'd0);
        check(cls == 4'd15, "R1", "class", 32'(cls), 32'd15);
        check(regn == 4'd0, "R1", "register", 32'(regn), 32'd0);
        check(ext == 3'd0, "R1", "ext words", 32'(ext), 32'd0);
        check(ill == 1'b0, "R1", "illegal", 32'(ill), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && cls == 4'd15, "R1", "after release",
              32'(cls), 32'd15);

        // Full sweep, back to back, legal and reserved sizes (R2..R8)
        for (int z = 0; z < 8; z++) begin
            for (int s = 0; s < 64; s++) send(6'(s), 3'(z));
        end
        // Immediate against every size with gaps between strobes (R6, R7)
        for (int z = 0; z < 8; z++) begin
            send(6'o74, 3'(z));
            idle(z % 3);
        end
        idle(3);
        check(exp_q.size() == 0, "R9", "results outstanding",
              32'(exp_q.size()), 32'd0);

        // R10: outputs hold with valid low and inputs moving
        send(6'o71, 3'd2);
        idle(2);
        held = '{cls: cls, regn: regn, ext: ext, ill: ill};
        for (int i = 0; i < 6; i++) begin
            idle(1);
            check(done == 1'b0, "R9", "done while idle", 32'(done), 32'd0);
            check({cls, regn, ext, ill} == held, "R10", "hold",
                  32'({cls, regn, ext, ill}), 32'(held));
        end
        send(6'o77, 3'd0);   // illegal after hold
        idle(3);
        check(exp_q.size() == 0, "R9", "results outstanding",
              32'(exp_q.size()), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R9", "watchdog expired", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule